// File: doc/BRIEF.md
# Four-Bit Universal Shift Register with Selectable Strobe Sensitivity

This block holds a small word that can be kept, moved one place toward bit 0 with a serial bit entering at the top, moved one place toward the top with a serial bit entering at bit 0, or replaced by a parallel word. A two-bit mode input picks the operation. All storage runs on one system clock. A separate strobe input decides when an operation takes effect: the strobe passes through a two-flop synchroniser, and a build-time parameter selects either level capture (one update for every clock the synchronised strobe is high) or edge capture (one update for each low-to-high change of the synchronised strobe).

An active-low clear empties the register and overrides strobe, mode and data. The clear takes effect as soon as it is asserted and is released on a clock edge. An optional pipeline of `OUT_LAT` registers delays the parallel output. Moving the word toward bit 0 halves the unsigned value it holds, and moving it toward the top doubles it, so the block can also serve as a divide-by-two and multiply-by-two stage.

Top module: `usr_shift4`

## Requirements
- R1: With mode 2'b11, a capture copies `din` into the stored word (bit 3 is the most significant bit).
- R2: With mode 2'b01, a capture moves bit 3 to bit 2, bit 2 to bit 1 and bit 1 to bit 0, and `sin_r` enters bit 3.
- R3: With mode 2'b10, a capture moves bit 0 to bit 1, bit 1 to bit 2 and bit 2 to bit 3, and `sin_l` enters bit 0.
- R4: With mode 2'b00, a capture leaves the stored word unchanged whatever `din`, `sin_l` and `sin_r` carry.
- R5: While `clr_n` is 0, `dout` is 0 and the stored word and output pipeline are zeroed, regardless of strobe, mode or data; this takes effect without waiting for a clock edge.
- R6: With `EDGE_CAP` = 0, the register performs one capture on every clock edge at which the twice-synchronised strobe is 1; a strobe raised between edges k and k+1 first changes the stored word at edge k+3.
- R7: With `EDGE_CAP` = 1, the register performs exactly one capture for each 0-to-1 change of the synchronised strobe; a strobe held high, held low or falling causes no further capture.
- R8: With `EDGE_CAP` = 1, a strobe that is already 1 when `clr_n` is released causes no capture.
- R9: `dout` shows the stored word delayed by exactly `OUT_LAT` system clocks.
- R10: With 0 serial fill, a shift under mode 2'b01 halves the unsigned value (rounding down) and a shift under mode 2'b10 doubles it modulo 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Active-low clear, asserted at once, released on a clock edge |
| mode | input | 2 | 00 keep, 01 move toward bit 0, 10 move toward bit 3, 11 parallel load |
| sin_l | input | 1 | Serial bit entering bit 0 in mode 10 |
| sin_r | input | 1 | Serial bit entering bit 3 in mode 01 |
| din | input | WIDTH | Parallel data word |
| strobe | input | 1 | Capture strobe, asynchronous to clk |
| dout | output | WIDTH | Stored word after the output pipeline |

## Verification
On every clock, the assertions check the next-state rule of each mode against the word held one cycle earlier, that the word and the output are zero while the clear is active, and, in edge builds, that a capture pulse never lasts two cycles. Only the bench scenarios show the end-to-end timing: the three-edge path from strobe to stored word, the exact output delay of the pipeline, how many captures a long strobe gives in each build, the absence of a capture when the clear is released under a high strobe, and the arithmetic sequence 14, 7, 3, 6, 12.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UP   = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

    typedef struct packed {
        usr_mode_e mode;
        logic      fill_lo;
        logic      fill_hi;
    } usr_ctrl_t;

    function automatic usr_ctrl_t make_ctrl(input logic [1:0] m, input logic lo, input logic hi);
        usr_ctrl_t c;
        c.mode    = usr_mode_e'(m);
        c.fill_lo = lo;
        c.fill_hi = hi;
        return c;
    endfunction

endpackage

// File: rtl/usr_clear_sync.sv
module usr_clear_sync (
    input  logic clk,
    input  logic clr_n,
    output logic clr
);
    logic [1:0] rel_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) rel_q <= 2'b00;
        else        rel_q <= {rel_q[0], 1'b1};
    end

    assign clr = ~rel_q[1];

    p_clear_now_r5: assert property (@(posedge clk) !clr_n |-> clr)
        else $error("clear not active while clr_n low");
endmodule

// File: rtl/usr_strobe_sync.sv
module usr_strobe_sync #(
    parameter bit EDGE_CAP = 1'b0
) (
    input  logic clk,
    input  logic clr,
    input  logic strobe,
    output logic cap
);
    logic meta_q, stb_s;

    always_ff @(posedge clk) begin
        meta_q <= strobe;
        stb_s  <= meta_q;
    end

    generate
        if (EDGE_CAP) begin : g_edge
            logic stb_d;
            // history is forced high during clear so a strobe already high at release is not an edge
            always_ff @(posedge clk or posedge clr) begin
                if (clr) stb_d <= 1'b1;
                else     stb_d <= stb_s;
            end
            assign cap = stb_s & ~stb_d & ~clr;

            p_single_pulse_r7: assert property (@(posedge clk) disable iff (clr)
                cap |=> !cap)
                else $error("edge capture lasted two cycles");
        end else begin : g_level
            assign cap = stb_s & ~clr;
        end
    endgenerate
endmodule

// File: rtl/usr_core.sv
module usr_core
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             cap,
    input  usr_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0]   from_hi;
    logic [EXT-1:0]   from_lo;
    logic [WIDTH-1:0] sel;

    assign from_hi = {ctrl.fill_hi, q};
    assign from_lo = {q, ctrl.fill_lo};

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_comb begin
                unique case (ctrl.mode)
                    MODE_KEEP: sel[i] = q[i];
                    MODE_DOWN: sel[i] = from_hi[i+1];
                    MODE_UP:   sel[i] = from_lo[i];
                    MODE_LOAD: sel[i] = din[i];
                    default:   sel[i] = q[i];
                endcase
            end

            // each bit selects between new data and its own fed-back value
            always_ff @(posedge clk or posedge clr) begin
                if (clr)      q[i] <= 1'b0;
                else if (cap) q[i] <= sel[i];
            end
        end
    endgenerate

    p_load_r1: assert property (@(posedge clk) disable iff (clr)
        (cap && ctrl.mode == MODE_LOAD) |=> q == $past(din))
        else $error("parallel load wrong");
    p_down_r2: assert property (@(posedge clk) disable iff (clr)
        (cap && ctrl.mode == MODE_DOWN) |=> q == {$past(ctrl.fill_hi), $past(q[WIDTH-1:1])})
        else $error("move toward bit 0 wrong");
    p_up_r3: assert property (@(posedge clk) disable iff (clr)
        (cap && ctrl.mode == MODE_UP) |=> q == {$past(q[WIDTH-2:0]), $past(ctrl.fill_lo)})
        else $error("move toward top wrong");
    p_keep_r4: assert property (@(posedge clk) disable iff (clr)
        (ctrl.mode == MODE_KEEP || !cap) |=> $stable(q))
        else $error("word changed without an update");
    p_zero_r5: assert property (@(posedge clk) clr |-> q == '0)
        else $error("word not zero during clear");
endmodule

// File: rtl/usr_out_pipe.sv
module usr_out_pipe #(
    parameter int WIDTH   = 4,
    parameter int OUT_LAT = 0
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (OUT_LAT == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [WIDTH-1:0] stage [OUT_LAT];
            always_ff @(posedge clk or posedge clr) begin
                if (clr) begin
                    for (int s = 0; s < OUT_LAT; s++) stage[s] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int s = 1; s < OUT_LAT; s++) stage[s] <= stage[s-1];
                end
            end
            assign q = stage[OUT_LAT-1];

            p_first_stage_r9: assert property (@(posedge clk) disable iff (clr)
                1'b1 |=> stage[0] == $past(d))
                else $error("pipeline first stage wrong");
        end
    endgenerate
endmodule

// File: rtl/usr_shift4.sv
module usr_shift4
    import usr_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter bit EDGE_CAP = 1'b0,
    parameter int OUT_LAT  = 0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             sin_l,
    input  logic             sin_r,
    input  logic [WIDTH-1:0] din,
    input  logic             strobe,
    output logic [WIDTH-1:0] dout
);
    logic             clr;
    logic             cap;
    usr_ctrl_t        ctrl;
    logic [WIDTH-1:0] word;

    assign ctrl = make_ctrl(mode, sin_l, sin_r);

    usr_clear_sync u_clr (
        .clk   (clk),
        .clr_n (clr_n),
        .clr   (clr)
    );

    usr_strobe_sync #(.EDGE_CAP(EDGE_CAP)) u_stb (
        .clk    (clk),
        .clr    (clr),
        .strobe (strobe),
        .cap    (cap)
    );

    usr_core #(.WIDTH(WIDTH)) u_core (
        .clk  (clk),
        .clr  (clr),
        .cap  (cap),
        .ctrl (ctrl),
        .din  (din),
        .q    (word)
    );

    usr_out_pipe #(.WIDTH(WIDTH), .OUT_LAT(OUT_LAT)) u_pipe (
        .clk (clk),
        .clr (clr),
        .d   (word),
        .q   (dout)
    );

    p_out_zero_r5: assert property (@(posedge clk) clr |-> dout == '0)
        else $error("output not zero during clear");
endmodule

// File: tb/sim_usr_shift4.sv
module sim_usr_shift4;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       sin_l = 1'b0;
    logic       sin_r = 1'b0;
    logic [3:0] din = 4'h0;
    logic       strobe = 1'b0;
    logic [3:0] out_lvl, out_edg;

    int total = 0;
    int bad = 0;
    logic [3:0] exp_v;

    always #10 clk = ~clk;   // 50 MHz

    usr_shift4 #(.WIDTH(4), .EDGE_CAP(1'b0), .OUT_LAT(0)) u0 (
        .clk(clk), .clr_n(clr_n), .mode(mode), .sin_l(sin_l), .sin_r(sin_r),
        .din(din), .strobe(strobe), .dout(out_lvl));

    usr_shift4 #(.WIDTH(4), .EDGE_CAP(1'b1), .OUT_LAT(3)) u1 (
        .clk(clk), .clr_n(clr_n), .mode(mode), .sin_l(sin_l), .sin_r(sin_r),
        .din(din), .strobe(strobe), .dout(out_edg));

    task automatic chk(input string req, input string what, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // strobe high for exactly one clock: one capture in both builds
    task automatic pulse();
        @(negedge clk) strobe = 1'b1;
        @(negedge clk) strobe = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic op(input logic [1:0] m, input logic l, input logic r, input logic [3:0] d);
        @(negedge clk);
        mode = m; sin_l = l; sin_r = r; din = d;
        pulse();
        settle();
    endtask

    task automatic t_reset();
        chk("R5", "reset lvl", out_lvl, 4'd0);
        chk("R5", "reset edg", out_edg, 4'd0);
    endtask

    task automatic t_arith();
        op(2'b11, 0, 0, 4'd14);
        chk("R1", "load lvl", out_lvl, 4'd14);
        chk("R1", "load edg", out_edg, 4'd14);
        op(2'b01, 0, 0, 4'd0);
        chk("R2", "shr1 lvl", out_lvl, 4'd7);
        chk("R10", "shr1 edg", out_edg, 4'd7);
        op(2'b01, 0, 0, 4'd15);
        chk("R2", "shr2 lvl", out_lvl, 4'd3);
        chk("R10", "shr2 edg", out_edg, 4'd3);
        op(2'b10, 0, 0, 4'd15);
        chk("R3", "shl1 lvl", out_lvl, 4'd6);
        chk("R10", "shl1 edg", out_edg, 4'd6);
        op(2'b10, 0, 0, 4'd0);
        chk("R3", "shl2 lvl", out_lvl, 4'd12);
        chk("R10", "shl2 edg", out_edg, 4'd12);
    endtask

    task automatic t_fill_and_keep();
        op(2'b00, 1, 1, 4'd5);
        chk("R4", "keep lvl", out_lvl, 4'd12);
        chk("R4", "keep edg", out_edg, 4'd12);
        op(2'b01, 0, 1, 4'd0);
        chk("R2", "fill hi lvl", out_lvl, 4'b1110);
        op(2'b10, 1, 0, 4'd0);
        chk("R3", "fill lo lvl", out_lvl, 4'b1101);
        chk("R3", "fill lo edg", out_edg, 4'b1101);
    endtask

    task automatic t_latency();
        op(2'b11, 0, 0, 4'd0);
        @(negedge clk);
        mode = 2'b11; din = 4'd9;
        @(negedge clk) strobe = 1'b1;      // between edges k and k+1
        @(negedge clk) strobe = 1'b0;      // after edge k+1
        @(negedge clk);                    // after k+2
        chk("R6", "before k+3 lvl", out_lvl, 4'd0);
        @(negedge clk);                    // after k+3
        chk("R6", "at k+3 lvl", out_lvl, 4'd9);
        chk("R9", "at k+3 edg", out_edg, 4'd0);
        repeat (2) @(negedge clk);         // after k+5
        chk("R9", "at k+5 edg", out_edg, 4'd0);
        @(negedge clk);                    // after k+6
        chk("R9", "at k+6 edg", out_edg, 4'd9);
        settle();
    endtask

    task automatic t_long_strobe();
        op(2'b11, 0, 0, 4'd0);
        @(negedge clk);
        mode = 2'b10; sin_l = 1'b1;
        strobe = 1'b1;
        repeat (3) @(negedge clk);
        strobe = 1'b0;
        settle();
        chk("R6", "3 clocks high lvl", out_lvl, 4'b0111);
        chk("R7", "3 clocks high edg", out_edg, 4'b0001);
    endtask

    task automatic t_clear();
        op(2'b11, 0, 0, 4'd10);
        @(negedge clk);
        mode = 2'b11; din = 4'hF;
        #3 clr_n = 1'b0;
        #1;
        chk("R5", "clear at once lvl", out_lvl, 4'd0);
        chk("R5", "clear at once edg", out_edg, 4'd0);
        pulse();
        settle();
        chk("R5", "clear beats load lvl", out_lvl, 4'd0);
        chk("R5", "clear beats load edg", out_edg, 4'd0);
        @(negedge clk) strobe = 1'b1;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        settle();
        chk("R6", "release high lvl", out_lvl, 4'hF);
        chk("R8", "release high edg", out_edg, 4'd0);
        @(negedge clk) strobe = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        t_arith();
        t_fill_and_keep();
        t_latency();
        t_long_strobe();
        t_clear();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule